// File: doc/BRIEF.md
# Dual-Role Synchronous Serial Port

This block is an 8-bit SPI port that acts either as the clock-driving master or as a clocked slave, picked by a 4-bit mode field in a control register. One data register is shared by both directions. A write hands a byte to an internal shift register for sending. The byte shifted in lands back in the same register when the transfer completes. Software reaches the port through a small register interface with an address, a write strobe, a read strobe and a combinational read mux.

As master, the port makes SCK from a divided system clock (divide by 4, 16 or 64) or from an external timer pulse, with SCK toggling once per pulse. As slave, it follows an external SCK through a synchronizer. It can either honour an active-low select pin or run with select ignored. Two flags in the control register stay set until software writes them to zero. The write-collision flag marks a data write made while shifting. The overflow flag marks a slave byte that completed while the previous one was still unread; the new byte is dropped. There is no stream interface. The register strobes are single-cycle and never stalled, and data flow is paced by software reading the data register, not by ready signals.

Top module: `spi_port`

## Requirements
- R1: After reset, the control register (address 0) and the status register (address 2) read 0, and both sck_oe and sdo_oe are 0.
- R2: The control register holds the mode in bits [7:4]. Modes 0, 1 and 2 are master modes whose SCK half-period is 2, 8 and 32 system clocks. In mode 3, SCK toggles once per tmr_tick pulse, which gives half the pulse rate.
- R3: With the port enabled as master and idle, sck_out equals the polarity bit (control bit 2), and sck_oe is 1.
- R4: A transfer is 8 bits, MSB first. sdo changes on the SCK edge leaving idle, and sdi is sampled on the edge returning to idle. Afterwards the received byte reads at address 1, status bit 0 (buffer full) is 1 and status bit 1 (busy) is 0.
- R5: A data-register write while a transfer is in progress sets the collision flag (control bit 1) and is otherwise ignored. The flag stays 1 until cleared.
- R6: A control write clears a flag whose written bit is 0. A written 1 leaves the flag as it is, so it never sets a clear flag.
- R7: In slave mode, a byte that completes while buffer full is 1 sets the overflow flag (control bit 0) and is discarded. The data register keeps the earlier byte.
- R8: The overflow flag never sets in master mode. A later master transfer overwrites an unread byte.
- R9: Reading address 1 with reg_rd clears buffer full.
- R10: Mode 4 is slave with select. While ss_n is high, sdo_oe is 0 and SCK edges are ignored, and raising ss_n discards a partly received byte.
- R11: Mode 5 is slave with ss_n ignored. It transfers and drives sdo_oe whatever the ss_n level.
- R12: With the enable bit (control bit 3) at 0, or with a mode value of 6 to 15, sck_oe and sdo_oe are 0 and data writes start no transfer (busy stays 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register address: 0 control, 1 data, 2 status |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears buffer full on address 1) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| tmr_tick | input | 1 | External timer pulse for master mode 3 |
| sck_in | input | 1 | Serial clock from an external master |
| sck_out | output | 1 | Serial clock driven as master |
| sck_oe | output | 1 | Enable for sck_out |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Enable for sdo |
| ss_n | input | 1 | Active-low slave select |

## Verification
A wrong bit counter or phase bit appears within one SCK half-period as a misplaced edge, a misordered received byte, or a transfer that never sets buffer full. A wrong flag state shows in the next read of the control register. A stale flag after a clearing write, or a lost byte after an overflow, is visible at the next read of address 1. A slave that failed to reset on deselect returns a byte mixed from the aborted bits on the very next transfer.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  typedef enum logic [1:0] {
    ROLE_OFF    = 2'd0,
    ROLE_MASTER = 2'd1,
    ROLE_SLAVE  = 2'd2
  } role_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  // Modes 0..3 master, 4..5 slave, anything else is treated as off.
  function automatic role_e role_of(input logic en, input logic [3:0] mode);
    if (!en) return ROLE_OFF;
    case (mode)
      4'd0, 4'd1, 4'd2, 4'd3: return ROLE_MASTER;
      4'd4, 4'd5:             return ROLE_SLAVE;
      default:                return ROLE_OFF;
    endcase
  endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= RST_VAL;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= RST_VAL;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_baud.sv
module spi_baud #(
  parameter int DIV_FAST = 4,
  parameter int DIV_MID  = 16,
  parameter int DIV_SLOW = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] sel,
  input  logic       tmr_tick,
  output logic       half_tick
);
  localparam int H_FAST = DIV_FAST / 2;
  localparam int H_MID  = DIV_MID / 2;
  localparam int H_SLOW = DIV_SLOW / 2;
  localparam int CW     = $clog2(H_SLOW + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          hit;

  always_comb begin
    case (sel)
      2'd0:    lim = CW'(H_FAST);
      2'd1:    lim = CW'(H_MID);
      default: lim = CW'(H_SLOW);
    endcase
  end

  assign hit = (cnt == lim - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (!run || hit)     cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end

  // Mode 3: every timer pulse is one SCK half-period.
  assign half_tick = run && ((sel == 2'd3) ? tmr_tick : hit);

  // R2: a divided half-period is never shorter than two clocks
  p_div_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && sel != 2'd3 && half_tick) |=> !half_tick);
endmodule

// File: rtl/spi_engine.sv
module spi_engine
  import spi_port_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  role_e         role,
  input  logic          m_half,
  input  logic          s_lead,
  input  logic          s_trail,
  input  logic          sel_ok,
  input  logic          load,
  input  logic [DW-1:0] load_word,
  input  logic          sdi,
  output logic          busy,
  output logic          phase,
  output logic          sdo_bit,
  output logic          done,
  output logic [DW-1:0] rx_word
);
  localparam int EDGES = 2 * DW;
  localparam int CW    = $clog2(EDGES);

  logic [DW-1:0] sr;
  logic [CW-1:0] cnt;
  logic          mrun;
  logic          sdo_q;
  logic          hold, edge_ev, lead, trail, last;

  assign hold    = (role == ROLE_OFF) || (role == ROLE_SLAVE && !sel_ok);
  assign edge_ev = (role == ROLE_MASTER) ? (mrun && m_half) : 1'b0;
  // Even count: next edge leaves idle; odd count: next edge returns to idle.
  assign lead  = !cnt[0] && ((role == ROLE_MASTER) ? edge_ev : (role == ROLE_SLAVE && s_lead));
  assign trail =  cnt[0] && ((role == ROLE_MASTER) ? edge_ev : (role == ROLE_SLAVE && s_trail));
  assign last  = trail && (cnt == CW'(EDGES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr    <= '0;
      cnt   <= '0;
      mrun  <= 1'b0;
      sdo_q <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (hold) begin
        cnt  <= '0;
        mrun <= 1'b0;
      end else begin
        if (lead) begin
          sdo_q <= sr[DW-1];
          cnt   <= cnt + 1'b1;
        end
        if (trail) begin
          sr <= {sr[DW-2:0], sdi};
          if (last) begin
            cnt  <= '0;
            mrun <= 1'b0;
            done <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
      if (load) begin
        sr   <= load_word;
        mrun <= (role == ROLE_MASTER);
      end
    end
  end

  assign busy    = mrun || (cnt != '0);
  assign phase   = cnt[0];
  assign sdo_bit = sdo_q;
  assign rx_word = sr;

  // R4: completion leaves the engine idle
  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R10: a deselected slave has its bit count cleared by the next cycle
  p_desel_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (role == ROLE_SLAVE && !sel_ok) |=> (cnt == '0));
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int DW          = 8,
  parameter int DIV_FAST    = 4,
  parameter int DIV_MID     = 16,
  parameter int DIV_SLOW    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          tmr_tick,
  input  logic          sck_in,
  output logic          sck_out,
  output logic          sck_oe,
  input  logic          sdi,
  output logic          sdo,
  output logic          sdo_oe,
  input  logic          ss_n
);
  // Control register fields
  logic [3:0]    mode_q;
  logic          en_q, cpol_q, wcol_q, ovf_q;
  logic [DW-1:0] buf_q;
  logic          bf_q;

  role_e role;
  logic  is_m, is_s;
  logic  sck_s, ss_s, sck_prev;
  logic  s_edge, s_lead, s_trail, sel_ok;
  logic  wr_ctrl, wr_data, rd_data, load, wcol_set;
  logic  busy, phase, sdo_bit, done, m_half;
  logic  drop, keep;
  logic [DW-1:0] rx_word;

  assign role = role_of(en_q, mode_q);
  assign is_m = (role == ROLE_MASTER);
  assign is_s = (role == ROLE_SLAVE);

  spi_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ss_n, sck_in}),
    .q     ({ss_s, sck_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_prev <= 1'b0;
    else        sck_prev <= sck_s;
  end

  assign s_edge  = sck_s ^ sck_prev;
  assign s_lead  = s_edge && (sck_s != cpol_q);
  assign s_trail = s_edge && (sck_s == cpol_q);
  // Mode 5 (bit 0 set) ignores select; mode 4 needs ss_n low.
  assign sel_ok  = is_s && (mode_q[0] || !ss_s);

  spi_baud #(.DIV_FAST(DIV_FAST), .DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)) u_baud (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (is_m && busy),
    .sel       (mode_q[1:0]),
    .tmr_tick  (tmr_tick),
    .half_tick (m_half)
  );

  assign wr_ctrl  = reg_wr && (reg_addr == ADDR_CTRL);
  assign wr_data  = reg_wr && (reg_addr == ADDR_DATA);
  assign rd_data  = reg_rd && (reg_addr == ADDR_DATA);
  assign load     = wr_data && (role != ROLE_OFF) && !busy;
  assign wcol_set = wr_data && (role != ROLE_OFF) && busy;

  spi_engine #(.DW(DW)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .role      (role),
    .m_half    (m_half),
    .s_lead    (s_lead),
    .s_trail   (s_trail),
    .sel_ok    (sel_ok),
    .load      (load),
    .load_word (reg_wdata),
    .sdi       (sdi),
    .busy      (busy),
    .phase     (phase),
    .sdo_bit   (sdo_bit),
    .done      (done),
    .rx_word   (rx_word)
  );

  // A slave byte arriving on an unread buffer is dropped.
  assign drop = done && is_s && bf_q;
  assign keep = done && !drop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      en_q   <= 1'b0;
      cpol_q <= 1'b0;
      wcol_q <= 1'b0;
      ovf_q  <= 1'b0;
      buf_q  <= '0;
      bf_q   <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        mode_q <= reg_wdata[7:4];
        en_q   <= reg_wdata[3];
        cpol_q <= reg_wdata[2];
      end
      if (wcol_set)                     wcol_q <= 1'b1;
      else if (wr_ctrl && !reg_wdata[1]) wcol_q <= 1'b0;
      if (drop)                         ovf_q <= 1'b1;
      else if (wr_ctrl && !reg_wdata[0]) ovf_q <= 1'b0;
      if (keep) begin
        buf_q <= rx_word;
        bf_q  <= 1'b1;
      end else if (rd_data) begin
        bf_q  <= 1'b0;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      ADDR_CTRL: reg_rdata = {mode_q, en_q, cpol_q, wcol_q, ovf_q};
      ADDR_DATA: reg_rdata = buf_q;
      ADDR_STAT: reg_rdata = {{(DW-2){1'b0}}, busy, bf_q};
      default:   reg_rdata = '0;
    endcase
  end

  assign sck_out = cpol_q ^ (is_m & phase);
  assign sck_oe  = is_m;
  assign sdo     = sdo_bit;
  assign sdo_oe  = is_m | sel_ok;

  // R5: collision flag is sticky until a clearing control write
  p_wcol_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wcol_q && !(wr_ctrl && !reg_wdata[1])) |=> wcol_q);
  // R7: slave overflow sets the flag and leaves the buffer untouched
  p_ovf_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && is_s && bf_q) |=> (ovf_q && $stable(buf_q)));
  // R8: no overflow can arise while acting as master
  p_no_ovf_master_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_m && !ovf_q) |=> !ovf_q);
  // R12: a disabled port has no transfer running on the next cycle
  p_off_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (role == ROLE_OFF) |=> !busy);
endmodule

// File: tb/tb_spi_port.sv
module tb_spi_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       tmr_tick = 1'b0;
  logic       sck_in = 1'b0;
  logic       sck_out, sck_oe, sdo, sdo_oe;
  logic       sdi = 1'b0;
  logic       ss_n = 1'b1;

  int n_tests = 0;
  int n_fail  = 0;
  logic tick_on = 1'b0;
  int tdiv = 0;

  always #10 clk = ~clk;

  spi_port dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tmr_tick(tmr_tick), .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
    .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe), .ss_n(ss_n)
  );

  always @(negedge clk) begin
    if (tick_on) begin
      tdiv = (tdiv == 4) ? 0 : tdiv + 1;
      tmr_tick = (tdiv == 0);
    end else begin
      tmr_tick = 1'b0;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // Master transfer with a bench slave model driving sdi and capturing sdo.
  task automatic m_xfer(input logic [3:0] mode, input logic cpol, input logic [7:0] tx,
                        input logic [7:0] rxp, input int half, input logic do_read);
    logic [7:0] cap = 8'd0;
    logic [7:0] v;
    logic last;
    int gap;
    int bad_gap = 0;
    int bi = 0;
    wr(2'd0, {mode, 1'b1, cpol, 2'b00});
    @(negedge clk);
    check("R3 idle level", {30'd0, sck_oe, sck_out}, {30'd0, 1'b1, cpol});
    wr(2'd1, tx);
    for (int e = 0; e < 16; e++) begin
      last = sck_out;
      gap = 0;
      while (sck_out == last) begin
        @(negedge clk);
        gap++;
      end
      if (e > 0 && gap != half) bad_gap++;
      if (sck_out != cpol) begin
        sdi = rxp[7 - bi];
      end else begin
        cap = {cap[6:0], sdo};
        bi++;
      end
    end
    check("R2 half-period mismatches", bad_gap, 0);
    repeat (4) @(negedge clk);
    peek(2'd2, v);
    check("R4 status after master transfer", v, 8'h01);
    check("R4 transmitted byte MSB first", cap, tx);
    peek(2'd0, v);
    check("R8 overflow stays clear in master", v[0], 0);
    if (do_read) begin
      rd(2'd1, v);
      check("R4 received byte", v, rxp);
      peek(2'd2, v);
      check("R9 buffer full cleared by read", v[0], 0);
    end
  endtask

  // Bench acts as master towards the slave port.
  task automatic s_bits(input logic cpol, input logic [7:0] b, input int nb,
                        output logic [7:0] cap);
    cap = 8'd0;
    for (int i = 7; i > 7 - nb; i--) begin
      @(negedge clk);
      sdi = b[i];
      sck_in = ~cpol;
      repeat (6) @(negedge clk);
      cap = {cap[6:0], sdo};
      sck_in = cpol;
      repeat (6) @(negedge clk);
    end
  endtask

  initial begin
    logic [7:0] v;
    logic [7:0] cap;
    logic [7:0] tx, rx;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    peek(2'd0, v); check("R1 control after reset", v, 8'h00);
    peek(2'd2, v); check("R1 status after reset", v, 8'h00);
    check("R1 output enables after reset", {sck_oe, sdo_oe}, 0);

    // R2/R3/R4: master sweep over divided modes and both polarities
    for (int m = 0; m < 3; m++) begin
      for (int p = 0; p < 2; p++) begin
        tx = 8'hA5 ^ 8'(m * 37 + p * 91);
        rx = {tx[3:0], ~tx[7:4]};
        m_xfer(4'(m), p[0], tx, rx, (m == 0) ? 2 : (m == 1) ? 8 : 32, 1'b1);
      end
    end
    // R2: timer-driven master rate, toggling once per pulse (5 clocks)
    tick_on = 1'b1;
    m_xfer(4'd3, 1'b0, 8'h3C, 8'hC1, 5, 1'b1);
    m_xfer(4'd3, 1'b1, 8'h81, 8'h7E, 5, 1'b1);
    tick_on = 1'b0;

    // R8: two master transfers without a read overwrite, no overflow
    m_xfer(4'd0, 1'b0, 8'h12, 8'h34, 2, 1'b0);
    m_xfer(4'd0, 1'b0, 8'h56, 8'h9B, 2, 1'b1);

    // R5: collision
    wr(2'd0, 8'h08);
    wr(2'd1, 8'hF0);
    wr(2'd1, 8'h0F);
    peek(2'd0, v); check("R5 collision flag set", v[1], 1);
    repeat (60) @(negedge clk);
    peek(2'd0, v); check("R5 collision flag sticky", v[1], 1);
    peek(2'd2, v); check("R5 ignored write starts nothing", v[1], 0);
    // R6: writing 1 keeps, writing 0 clears
    wr(2'd0, 8'h0A);
    peek(2'd0, v); check("R6 written 1 keeps flag", v[1], 1);
    wr(2'd0, 8'h08);
    peek(2'd0, v); check("R6 written 0 clears flag", v[1], 0);
    wr(2'd0, 8'h0B);
    peek(2'd0, v); check("R6 written 1 does not set flags", v[1:0], 0);
    rd(2'd1, v);

    // Slave with select, cpol 0
    sck_in = 1'b0; ss_n = 1'b0;
    wr(2'd0, 8'h48);
    wr(2'd1, 8'hC6);
    s_bits(1'b0, 8'h5D, 8, cap);
    repeat (6) @(negedge clk);
    check("R4 slave transmitted byte", cap, 8'hC6);
    peek(2'd2, v); check("R4 slave buffer full", v, 8'h01);
    // R7: second byte without reading
    s_bits(1'b0, 8'hE2, 8, cap);
    repeat (6) @(negedge clk);
    peek(2'd0, v); check("R7 overflow flag set", v[0], 1);
    rd(2'd1, v); check("R7 buffer keeps earlier byte", v, 8'h5D);
    wr(2'd0, 8'h48);
    peek(2'd0, v); check("R6 overflow cleared", v[0], 0);

    // R10: deselected slave
    ss_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 sdo disabled while deselected", sdo_oe, 0);
    s_bits(1'b0, 8'hAA, 8, cap);
    repeat (6) @(negedge clk);
    peek(2'd2, v); check("R10 SCK ignored while deselected", v, 8'h00);
    ss_n = 1'b0;
    s_bits(1'b0, 8'hFF, 3, cap);
    ss_n = 1'b1;
    repeat (6) @(negedge clk);
    ss_n = 1'b0;
    repeat (4) @(negedge clk);
    s_bits(1'b0, 8'h5A, 8, cap);
    repeat (6) @(negedge clk);
    rd(2'd1, v); check("R10 deselect discards partial byte", v, 8'h5A);

    // R11: slave ignoring select, cpol 1
    ss_n = 1'b1; sck_in = 1'b1;
    wr(2'd0, 8'h5C);
    repeat (4) @(negedge clk);
    check("R11 sdo driven with select high", sdo_oe, 1);
    s_bits(1'b1, 8'hC3, 8, cap);
    repeat (6) @(negedge clk);
    rd(2'd1, v); check("R11 byte received with select ignored", v, 8'hC3);
    sck_in = 1'b0;

    // R12: invalid mode and disabled port
    wr(2'd0, 8'h88);
    wr(2'd1, 8'h11);
    repeat (4) @(negedge clk);
    peek(2'd2, v); check("R12 invalid mode no transfer", v[1], 0);
    check("R12 invalid mode enables off", {sck_oe, sdo_oe}, 0);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h22);
    repeat (4) @(negedge clk);
    peek(2'd2, v); check("R12 disabled no transfer", v[1], 0);
    check("R12 disabled enables off", {sck_oe, sdo_oe}, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule